// File: doc/BRIEF.md
# Fully Associative Address Translation Cache with Space Tags

This block caches virtual-to-physical page translations for a small processor memory path. Every slot is compared against the request at once. A slot answers only when it holds a translation, its virtual page number matches the request, and its address-space tag matches the current space register. On a hit the physical address is the stored frame number placed above the unchanged page offset, and the slot's protection bits are returned with it. On a miss the block raises a miss pulse and does nothing else. Software then walks the page tables itself, installs the translation through the fill port and retries the access, which now hits.

Because every slot carries the space tag, the tag register can be changed on a process switch and the entries of other processes can stay in place. A flush command drops every ordinary entry. Pinned entries are installed with a flag set. A flush keeps them, and replacement never picks them.

When a fill needs a slot, it takes the lowest-numbered empty unpinned slot. If there is none, it takes the unpinned slot that was used longest ago. A fill whose page number and space tag are already present rewrites that slot in place.

Top module: `xc_tlb`

## Requirements
- R1: After reset every slot is empty, the current space tag is 0, the hit and miss outputs are low, and the first lookup misses.
- R2: A lookup presented at one clock edge reports its result in the registers after that edge. On a hit, `lk_paddr_o` equals {stored frame number, `lk_ofs_i`}, with the offset in bits [OFS_W-1:0].
- R3: A slot matches only if it is valid, its page number equals `lk_vpn_i`, and its space tag equals the current space tag register. A write through `asid_we_i` applies to lookups presented from the next edge on.
- R4: For each cycle with `lk_req_i` high, exactly one of `lk_hit_o`/`lk_miss_o` pulses in the following cycle. Neither pulses without a request. `lk_paddr_o` and `lk_prot_o` read 0 after a miss.
- R5: A fill stores the page number, frame number, protection bits and pinned flag, tagged with the current space tag. A retried lookup then hits and returns the stored protection bits on `lk_prot_o`.
- R6: A fill with no existing match goes to the lowest-numbered empty slot that is not pinned, if one exists.
- R7: Otherwise the fill evicts the least recently used unpinned slot. Both lookup hits and fills count as uses.
- R8: A fill whose page number and space tag already exist rewrites that slot in place. No two slots ever match one lookup.
- R9: A pinned slot is never chosen for eviction.
- R10: A flush clears the valid bit of every unpinned slot and leaves pinned slots valid and unchanged.
- R11: A fill in the same cycle as a flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| lk_req_i | input | 1 | Lookup request |
| lk_vpn_i | input | VPN_W | Lookup virtual page number |
| lk_ofs_i | input | OFS_W | Lookup page offset |
| lk_hit_o | output | 1 | Lookup hit pulse |
| lk_miss_o | output | 1 | Lookup miss pulse (exception to software) |
| lk_paddr_o | output | PFN_W+OFS_W | Physical address on a hit |
| lk_prot_o | output | PROT_W | Protection bits of the hit slot |
| asid_we_i | input | 1 | Current space tag write |
| asid_wdata_i | input | ASID_W | New space tag |
| flush_i | input | 1 | Drop all unpinned entries |
| fill_we_i | input | 1 | Install a translation |
| fill_vpn_i | input | VPN_W | Page number to install |
| fill_pfn_i | input | PFN_W | Frame number to install |
| fill_prot_i | input | PROT_W | Protection bits to install |
| fill_wired_i | input | 1 | Pin the installed entry |

## Verification
Each lookup result is registered once, so hit, miss, address and protection bits are due exactly one edge after the request edge. The bench drives every operation on a falling edge and removes it on the next falling edge. It reads the outputs at that same point, half a cycle after the single register stage. Fills, flushes and tag writes take effect at the edge they are presented on, so the bench puts the following lookup one full cycle later. Replacement results are checked through the lookups that follow, never through internal state.

// File: rtl/xc_pkg.sv
package xc_pkg;
   // where a fill lands
   typedef enum logic [1:0] {
      FILL_NONE = 2'd0,
      FILL_SAME = 2'd1,
      FILL_FREE = 2'd2,
      FILL_OLD  = 2'd3
   } fill_src_e;
endpackage

// File: rtl/xc_cam.sv
module xc_cam #(
   parameter int N     = 8,
   parameter int KEY_W = 18
) (
   input  logic [N-1:0]            valid_i,
   input  logic [N-1:0][KEY_W-1:0] key_i,
   input  logic [KEY_W-1:0]        probe_i,
   output logic [N-1:0]            hit_o
);
   if (N < 1) begin : g_bad_n
      $error("xc_cam: N must be at least 1");
   end
   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign hit_o[g] = valid_i[g] && (key_i[g] == probe_i);
   end
endmodule

// File: rtl/xc_enc.sv
module xc_enc #(
   parameter int N  = 8,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  vec_i,
   output logic [IW-1:0] idx_o,
   output logic          any_o
);
   always_comb begin
      idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (vec_i[i]) idx_o = idx_o | IW'(i);
      end
   end
   assign any_o = |vec_i;
endmodule

// File: rtl/xc_lru.sv
module xc_lru #(
   parameter int N  = 8,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          touch_i,
   input  logic [IW-1:0] touch_idx_i,
   input  logic [N-1:0]  valid_i,
   input  logic [N-1:0]  wired_i,
   output logic [IW-1:0] victim_idx_o,
   output logic          victim_ok_o,
   output logic          victim_free_o
);
   if (N < 2) begin : g_bad_n
      $error("xc_lru: N must be at least 2");
   end

   // rank 0 = most recent, N-1 = oldest
   logic [N-1:0][IW-1:0] rank_q;
   logic [IW-1:0]        free_idx, old_idx, best;
   logic                 free_ok, old_ok;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         for (int j = 0; j < N; j++) rank_q[j] <= IW'(j);
      end else if (touch_i) begin
         for (int j = 0; j < N; j++) begin
            if (IW'(j) == touch_idx_i)             rank_q[j] <= '0;
            else if (rank_q[j] < rank_q[touch_idx_i]) rank_q[j] <= rank_q[j] + 1'b1;
         end
      end
   end

   always_comb begin
      free_ok  = 1'b0;
      free_idx = '0;
      for (int j = N - 1; j >= 0; j--) begin
         if (!valid_i[j] && !wired_i[j]) begin
            free_ok  = 1'b1;
            free_idx = IW'(j);
         end
      end
      old_ok  = 1'b0;
      old_idx = '0;
      best    = '0;
      for (int j = 0; j < N; j++) begin
         if (!wired_i[j] && (!old_ok || rank_q[j] > best)) begin
            old_ok  = 1'b1;
            old_idx = IW'(j);
            best    = rank_q[j];
         end
      end
   end

   assign victim_idx_o  = free_ok ? free_idx : old_idx;
   assign victim_ok_o   = free_ok || old_ok;
   assign victim_free_o = free_ok;
endmodule

// File: rtl/xc_tlb.sv
module xc_tlb #(
   parameter int N      = 8,
   parameter int VPN_W  = 10,
   parameter int PFN_W  = 7,
   parameter int ASID_W = 8,
   parameter int OFS_W  = 5,
   parameter int PROT_W = 2
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   lk_req_i,
   input  logic [VPN_W-1:0]       lk_vpn_i,
   input  logic [OFS_W-1:0]       lk_ofs_i,
   output logic                   lk_hit_o,
   output logic                   lk_miss_o,
   output logic [PFN_W+OFS_W-1:0] lk_paddr_o,
   output logic [PROT_W-1:0]      lk_prot_o,
   input  logic                   asid_we_i,
   input  logic [ASID_W-1:0]      asid_wdata_i,
   input  logic                   flush_i,
   input  logic                   fill_we_i,
   input  logic [VPN_W-1:0]       fill_vpn_i,
   input  logic [PFN_W-1:0]       fill_pfn_i,
   input  logic [PROT_W-1:0]      fill_prot_i,
   input  logic                   fill_wired_i
);
   import xc_pkg::*;

   localparam int IW    = $clog2(N);
   localparam int KEY_W = ASID_W + VPN_W;
   localparam int PA_W  = PFN_W + OFS_W;

   if (N < 2 || VPN_W < 1 || PFN_W < 1 || ASID_W < 1 || OFS_W < 1 || PROT_W < 1) begin : g_bad_cfg
      $error("xc_tlb: illegal parameter set");
   end

   logic [N-1:0]             valid_q, wired_q;
   logic [N-1:0][KEY_W-1:0]  key_q;
   logic [N-1:0][PFN_W-1:0]  pfn_q;
   logic [N-1:0][PROT_W-1:0] prot_q;
   logic [ASID_W-1:0]        asid_q;

   logic [N-1:0]  lk_match, fl_match;
   logic [IW-1:0] lk_idx, fl_same_idx, victim_idx, fill_idx, touch_idx;
   logic          lk_any, fl_same, victim_ok, victim_free, fill_go, touch;
   fill_src_e     fill_src;

   xc_cam #(.N(N), .KEY_W(KEY_W)) u_lk_cam (
      .valid_i(valid_q), .key_i(key_q), .probe_i({asid_q, lk_vpn_i}), .hit_o(lk_match));
   xc_cam #(.N(N), .KEY_W(KEY_W)) u_fl_cam (
      .valid_i(valid_q), .key_i(key_q), .probe_i({asid_q, fill_vpn_i}), .hit_o(fl_match));
   xc_enc #(.N(N), .IW(IW)) u_lk_enc (.vec_i(lk_match), .idx_o(lk_idx), .any_o(lk_any));
   xc_enc #(.N(N), .IW(IW)) u_fl_enc (.vec_i(fl_match), .idx_o(fl_same_idx), .any_o(fl_same));

   always_comb begin
      if (!fill_we_i || flush_i) fill_src = FILL_NONE;
      else if (fl_same)           fill_src = FILL_SAME;
      else if (!victim_ok)        fill_src = FILL_NONE;
      else if (victim_free)       fill_src = FILL_FREE;
      else                        fill_src = FILL_OLD;
   end

   assign fill_go   = (fill_src != FILL_NONE);
   assign fill_idx  = (fill_src == FILL_SAME) ? fl_same_idx : victim_idx;
   assign touch     = fill_go || (lk_req_i && lk_any && !flush_i);
   assign touch_idx = fill_go ? fill_idx : lk_idx;

   xc_lru #(.N(N), .IW(IW)) u_lru (
      .clk_i(clk_i), .rst_ni(rst_ni), .touch_i(touch), .touch_idx_i(touch_idx),
      .valid_i(valid_q), .wired_i(wired_q),
      .victim_idx_o(victim_idx), .victim_ok_o(victim_ok), .victim_free_o(victim_free));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         valid_q <= '0;
         wired_q <= '0;
         key_q   <= '0;
         pfn_q   <= '0;
         prot_q  <= '0;
         asid_q  <= '0;
      end else begin
         if (asid_we_i) asid_q <= asid_wdata_i;
         if (flush_i) begin
            valid_q <= valid_q & wired_q;
         end else if (fill_go) begin
            valid_q[fill_idx] <= 1'b1;
            wired_q[fill_idx] <= fill_wired_i;
            key_q[fill_idx]   <= {asid_q, fill_vpn_i};
            pfn_q[fill_idx]   <= fill_pfn_i;
            prot_q[fill_idx]  <= fill_prot_i;
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         lk_hit_o   <= 1'b0;
         lk_miss_o  <= 1'b0;
         lk_paddr_o <= '0;
         lk_prot_o  <= '0;
      end else begin
         lk_hit_o   <= lk_req_i && lk_any;
         lk_miss_o  <= lk_req_i && !lk_any;
         lk_paddr_o <= (lk_req_i && lk_any) ? PA_W'({pfn_q[lk_idx], lk_ofs_i}) : '0;
         lk_prot_o  <= (lk_req_i && lk_any) ? prot_q[lk_idx] : '0;
      end
   end
endmodule

// File: rtl/xc_tlb_chk.sv
module xc_tlb_chk #(
   parameter int N     = 8,
   parameter int OFS_W = 5,
   parameter int PA_W  = 12
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             lk_req_i,
   input logic [OFS_W-1:0] lk_ofs_i,
   input logic             lk_hit_o,
   input logic             lk_miss_o,
   input logic [PA_W-1:0]  lk_paddr_o,
   input logic             flush_i,
   input logic [N-1:0]     valid_q,
   input logic [N-1:0]     wired_q,
   input logic [N-1:0]     lk_match
);
   // R4
   hit_miss_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(lk_hit_o && lk_miss_o));
   // R4
   resp_due_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lk_req_i |=> (lk_hit_o || lk_miss_o));
   // R4
   no_resp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lk_req_i |=> !(lk_hit_o || lk_miss_o));
   // R2
   paddr_ofs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lk_req_i |=> (!lk_hit_o || lk_paddr_o[OFS_W-1:0] == $past(lk_ofs_i)));
   // R10
   flush_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i |=> (((valid_q & ~wired_q) == '0) && $stable(wired_q)));
   // R8
   single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(lk_match));
endmodule

bind xc_tlb xc_tlb_chk #(.N(N), .OFS_W(OFS_W), .PA_W(PFN_W + OFS_W)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .lk_req_i(lk_req_i), .lk_ofs_i(lk_ofs_i),
   .lk_hit_o(lk_hit_o), .lk_miss_o(lk_miss_o), .lk_paddr_o(lk_paddr_o),
   .flush_i(flush_i), .valid_q(valid_q), .wired_q(wired_q), .lk_match(lk_match));

// File: tb/test_xc_tlb.sv
`timescale 1ns/1ps
module test_xc_tlb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_req = 1'b0;
   logic [9:0]  lk_vpn = '0;
   logic [4:0]  lk_ofs = '0;
   logic        lk_hit, lk_miss;
   logic [11:0] lk_paddr;
   logic [1:0]  lk_prot;
   logic        asid_we = 1'b0;
   logic [7:0]  asid_wd = '0;
   logic        flush = 1'b0;
   logic        fill_we = 1'b0;
   logic [9:0]  fill_vpn = '0;
   logic [6:0]  fill_pfn = '0;
   logic [1:0]  fill_prot = '0;
   logic        fill_wired = 1'b0;
   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   xc_tlb i_xc_tlb (
      .clk_i(clk), .rst_ni(rst_n), .lk_req_i(lk_req), .lk_vpn_i(lk_vpn), .lk_ofs_i(lk_ofs),
      .lk_hit_o(lk_hit), .lk_miss_o(lk_miss), .lk_paddr_o(lk_paddr), .lk_prot_o(lk_prot),
      .asid_we_i(asid_we), .asid_wdata_i(asid_wd), .flush_i(flush),
      .fill_we_i(fill_we), .fill_vpn_i(fill_vpn), .fill_pfn_i(fill_pfn),
      .fill_prot_i(fill_prot), .fill_wired_i(fill_wired));

   // op: 0 lookup, 1 fill, 2 space tag write (tag in vpn), 3 flush
   typedef struct packed {
      logic [1:0]  op;
      logic [9:0]  vpn;
      logic [4:0]  ofs;
      logic [6:0]  pfn;
      logic        w;
      logic        h;
      logic [11:0] pa;
      logic [3:0]  rq;
   } vec_t;

   function automatic vec_t mk(input logic [1:0] op, input logic [9:0] vpn, input logic [4:0] ofs,
                               input logic [6:0] pfn, input logic w, input logic h,
                               input logic [11:0] pa, input logic [3:0] rq);
      vec_t v;
      v.op = op; v.vpn = vpn; v.ofs = ofs; v.pfn = pfn; v.w = w; v.h = h; v.pa = pa; v.rq = rq;
      return v;
   endfunction

   localparam int NV = 33;
   localparam vec_t VT [NV] = '{
      mk(2, 10'h001, 0, 0, 0, 0, 0, 3),
      mk(1, 10'h010, 0, 7'h20, 0, 0, 0, 6),
      mk(1, 10'h011, 0, 7'h21, 0, 0, 0, 6),
      mk(1, 10'h012, 0, 7'h22, 1, 0, 0, 9),
      mk(1, 10'h013, 0, 7'h23, 0, 0, 0, 6),
      mk(1, 10'h014, 0, 7'h24, 0, 0, 0, 6),
      mk(1, 10'h015, 0, 7'h25, 0, 0, 0, 6),
      mk(1, 10'h016, 0, 7'h26, 0, 0, 0, 6),
      mk(1, 10'h017, 0, 7'h27, 0, 0, 0, 6),
      mk(0, 10'h010, 5'd5, 0, 0, 1, 12'h405, 2),   // R2
      mk(0, 10'h017, 5'd31, 0, 0, 1, 12'h4FF, 6),  // R6 all eight placed
      mk(1, 10'h050, 0, 7'h55, 0, 0, 0, 7),
      mk(0, 10'h011, 5'd1, 0, 0, 0, 0, 7),         // R7 oldest slot evicted
      mk(0, 10'h050, 5'd2, 0, 0, 1, 12'hAA2, 5),   // R5 retried lookup hits
      mk(1, 10'h051, 0, 7'h66, 0, 0, 0, 9),
      mk(0, 10'h013, 5'd0, 0, 0, 0, 0, 9),         // R9 pinned skipped, next oldest gone
      mk(0, 10'h012, 5'd3, 0, 0, 1, 12'h443, 9),   // R9 pinned survives
      mk(0, 10'h051, 5'd0, 0, 0, 1, 12'hCC0, 7),
      mk(1, 10'h010, 0, 7'h3A, 0, 0, 0, 8),
      mk(0, 10'h010, 5'd4, 0, 0, 1, 12'h744, 8),   // R8 rewritten in place
      mk(2, 10'h002, 0, 0, 0, 0, 0, 3),
      mk(0, 10'h010, 5'd0, 0, 0, 0, 0, 3),         // R3 other space misses
      mk(1, 10'h010, 0, 7'h01, 0, 0, 0, 3),
      mk(0, 10'h010, 5'd0, 0, 0, 1, 12'h020, 3),   // R3
      mk(2, 10'h001, 0, 0, 0, 0, 0, 3),
      mk(0, 10'h010, 5'd0, 0, 0, 1, 12'h740, 8),   // R8 both spaces coexist
      mk(0, 10'h014, 5'd0, 0, 0, 0, 0, 7),         // R7
      mk(3, 10'h000, 0, 0, 0, 0, 0, 10),
      mk(0, 10'h012, 5'd3, 0, 0, 1, 12'h443, 10),  // R10 pinned kept
      mk(0, 10'h010, 5'd0, 0, 0, 0, 0, 10),        // R10 flushed
      mk(1, 10'h070, 0, 7'h11, 0, 0, 0, 6),
      mk(0, 10'h070, 5'd9, 0, 0, 1, 12'h229, 6),   // R6
      mk(0, 10'h051, 5'd0, 0, 0, 0, 0, 10)         // R10
   };

   task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   // drive on a falling edge, release on the next; results are then due
   task automatic do_op(input logic [1:0] op, input logic [9:0] vpn, input logic [4:0] ofs,
                        input logic [6:0] pfn, input logic [1:0] prot, input logic w, input logic fl);
      @(negedge clk);
      lk_req  = (op == 2'd0); lk_vpn = vpn; lk_ofs = ofs;
      fill_we = (op == 2'd1); fill_vpn = vpn; fill_pfn = pfn; fill_prot = prot; fill_wired = w;
      asid_we = (op == 2'd2); asid_wd = vpn[7:0];
      flush   = (op == 2'd3) || fl;
      @(negedge clk);
      lk_req = 1'b0; fill_we = 1'b0; asid_we = 1'b0; flush = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "hit after reset", 32'(lk_hit), 0);
      chk("R1", "miss after reset", 32'(lk_miss), 0);
      do_op(0, 10'h010, 0, 0, 0, 0, 0);
      chk("R1", "first lookup miss", 32'(lk_miss), 1);
      chk("R1", "first lookup hit", 32'(lk_hit), 0);

      for (int k = 0; k < NV; k++) begin
         do_op(VT[k].op, VT[k].vpn, VT[k].ofs, VT[k].pfn, 2'b01, VT[k].w, 1'b0);
         if (VT[k].op == 2'd0) begin
            chk($sformatf("R%0d", VT[k].rq), $sformatf("row %0d hit", k), 32'(lk_hit), 32'(VT[k].h));
            chk("R4", $sformatf("row %0d miss", k), 32'(lk_miss), 32'(!VT[k].h));
            chk($sformatf("R%0d", VT[k].rq), $sformatf("row %0d paddr", k), 32'(lk_paddr), 32'(VT[k].pa));
         end
      end

      // R4 no request, no pulse
      @(negedge clk);
      chk("R4", "idle hit", 32'(lk_hit), 0);
      chk("R4", "idle miss", 32'(lk_miss), 0);

      // R5 protection bits returned with the hit
      do_op(1, 10'h033, 0, 7'h05, 2'b10, 0, 0);
      do_op(0, 10'h033, 5'd7, 0, 0, 0, 0);
      chk("R5", "prot", 32'(lk_prot), 32'h2);
      chk("R5", "prot paddr", 32'(lk_paddr), 32'h0A7);

      // R11 fill dropped when flushed in the same cycle
      do_op(1, 10'h044, 0, 7'h09, 2'b01, 0, 1);
      do_op(0, 10'h044, 5'd0, 0, 0, 0, 0);
      chk("R11", "fill with flush", 32'(lk_miss), 1);
      do_op(0, 10'h012, 5'd3, 0, 0, 0, 0);
      chk("R11", "pinned after flush", 32'(lk_paddr), 32'h443);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule